// File: doc/BRIEF.md
# Two-Line Serial Target with Status Return

This block is the device side of a half-duplex serial link. The host drives the link in SPI mode 0, with an active-low select, and moves two bits per clock on a pair of bidirectional data lines. Every transaction opens with an 8-bit command and a 32-bit address. A write then streams data bytes, and each byte becomes a single-byte write on a simple memory port. A read first returns a 32-bit status word during sixteen turnaround clocks. It then streams data fetched as aligned little-endian words from the same port.

The command byte does more than select the direction. One field pulses one of seven downstream interrupt lines toward the local logic. A second field clears one of seven upstream pending flags, which local logic sets. An active-low interrupt pin stays low while any upstream flag is pending. The host polls the status word until that pin returns high, and it reads the link's health from the low status bits.

All link inputs pass through two-flop synchronisers into the system clock, which must run at least four times the serial clock. Raising the select at any point abandons the transaction. The data outputs are released and the decoder waits for a new command.

Top module: `dspi_target`

## Requirements
- R1: While the synchronised select is high, the data output enable is low and the decoder is in the command phase, so a transaction cut short at any point leaves no trace on the next one.
- R2: Command and address are shifted in most significant bit first, two bits per rising serial clock, with line 1 carrying the earlier (higher) bit. Command bit 7 selects read (1) or write (0). Bits 6:4 are a downstream index to raise and bits 2:0 are an upstream index to acknowledge, with 0 meaning none in both fields. Both fields act once the eighth command bit arrives, even if the select rises right after.
- R3: A nonzero raise index n gives exactly one system-clock pulse on dn_irq[n-1] and nothing on the other lines. Index 0 pulses nothing.
- R4: A pulse on up_set[k] makes upstream flag k+1 pending. An acknowledge index n clears pending flag n and leaves the others unchanged.
- R5: spi_irq_n is low exactly while at least one upstream flag is pending, and it is low on the clock after any up_set bit is seen.
- R6: Status layout: bit 0 is high when tgt_ready is low, bit 8 equals tgt_ready, bits 15:9 are pending upstream flags 7..1 (flag n at bit 8+n), and every other bit is 0. The word is taken at the end of the address phase, so an acknowledge in the same command is already reflected.
- R7: On a read, the 16 clocks after the address return the status word most significant pair first. The target changes its outputs after falling serial edges, and the output enable is high from the first turnaround clock on.
- R8: Read data starts at the aligned word holding the address. Bytes go out in ascending address order (word bits 7:0 first), each byte most significant pair first, and the word address advances by 4. A host that wants an unaligned start skips 4 clocks per byte of offset.
- R9: Each write byte (4 clocks, most significant pair first) issues one memory write. The address is aligned, the strobe is one-hot on lane address[1:0], the byte is copied to all four lanes, and the byte address increments after each byte.
- R10: Memory read requests are always word aligned with all strobes set, and mem_rdata is taken on the clock after mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_io_in | input | 2 | Data lines as received from the pads |
| spi_io_out | output | 2 | Data lines driven during reads |
| spi_io_oe | output | 1 | Output enable for both data lines |
| spi_irq_n | output | 1 | Active-low upstream pending indication |
| tgt_ready | input | 1 | Local logic is up; drives status bits 8 and 0 |
| up_set | input | 7 | Set pulses for upstream flags 1..7 |
| dn_irq | output | 7 | One-cycle pulses for downstream interrupts 1..7 |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write byte copied to every lane |
| mem_be | output | 4 | Byte strobes |
| mem_rdata | input | 32 | Read word, valid the clock after mem_req |

## Verification
Random reads and writes of 1 to 8 bytes at random byte addresses cover all four start offsets and word crossings. These cases separate the byte-order, padding and prefetch-increment behaviour. Every write is read back over the link and also compared with the memory model. This tells strobe-lane faults apart from shift-order faults. Directed cases set and acknowledge upstream flags one at a time, toggle readiness, send a command with no address, and cut transactions off during the address and data phases. These cases separate the status layout, the interrupt pin and the abort path.

// File: rtl/dspi_target.sv
module dspi_target (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic [1:0]  spi_io_in,
  output logic [1:0]  spi_io_out,
  output logic        spi_io_oe,
  output logic        spi_irq_n,
  input  logic        tgt_ready,
  input  logic [6:0]  up_set,
  output logic [6:0]  dn_irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata
);
  localparam int CMD_CLKS  = 4;
  localparam int ADDR_CLKS = 16;
  localparam int BYTE_CLKS = 4;
  localparam int WORD_CLKS = 16;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_WR, PH_RD} phase_t;

  logic [2:0]  sclk_q;
  logic [1:0]  cs_q;
  logic [1:0]  d_q1, d_q2;
  phase_t      phase;
  logic [3:0]  cnt, ocnt;
  logic [31:0] sh, osh, ptr, rd_buf;
  logic        rd_cmd, oe, rd_pend;
  logic [6:0]  up_pend;

  logic        cs_act, rise, fall, cmd_done, addr_done;
  logic [31:0] sh_next, status_w;

  function automatic logic [6:0] idx_mask(input logic [2:0] idx);
    return (idx == 3'd0) ? 7'd0 : (7'd1 << (idx - 3'd1));
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign cs_act    = ~cs_q[1];
  assign rise      = sclk_q[1] & ~sclk_q[2];
  assign fall      = ~sclk_q[1] & sclk_q[2];
  assign sh_next   = {sh[29:0], d_q2};
  assign cmd_done  = cs_act & rise & (phase == PH_CMD)  & (cnt == 4'(CMD_CLKS - 1));
  assign addr_done = cs_act & rise & (phase == PH_ADDR) & (cnt == 4'(ADDR_CLKS - 1));
  assign status_w  = {16'h0, up_pend, tgt_ready, 7'h0, ~tgt_ready};

  assign spi_io_out = oe ? osh[31:30] : 2'b00;
  assign spi_io_oe  = oe;
  assign spi_irq_n  = ~|up_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      d_q1   <= '0;
      d_q2   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[0], spi_cs_n};
      d_q1   <= spi_io_in;
      d_q2   <= d_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_pend <= '0;
      dn_irq  <= '0;
    end else begin
      up_pend <= (up_pend & ~(cmd_done ? idx_mask(sh_next[2:0]) : 7'd0)) | up_set;
      dn_irq  <= cmd_done ? idx_mask(sh_next[6:4]) : 7'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_buf  <= '0;
    end else begin
      rd_pend <= mem_req & ~mem_we;
      if (rd_pend) rd_buf <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      ocnt      <= '0;
      sh        <= '0;
      osh       <= '0;
      ptr       <= '0;
      rd_cmd    <= 1'b0;
      oe        <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_req <= 1'b0;
      if (!cs_act) begin
        phase <= PH_CMD;
        cnt   <= '0;
        oe    <= 1'b0;
      end else if (rise) begin
        case (phase)
          PH_CMD: begin
            sh  <= sh_next;
            cnt <= cnt + 4'd1;
            if (cmd_done) begin
              rd_cmd <= sh_next[7];
              phase  <= PH_ADDR;
              cnt    <= '0;
            end
          end
          PH_ADDR: begin
            sh  <= sh_next;
            cnt <= cnt + 4'd1;
            if (addr_done) begin
              cnt <= '0;
              if (rd_cmd) begin
                phase    <= PH_RD;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_be   <= 4'hF;
                mem_addr <= {sh_next[31:2], 2'b00};
                ptr      <= {sh_next[31:2], 2'b00} + 32'd4;
                osh      <= status_w;
                ocnt     <= '0;
              end else begin
                phase <= PH_WR;
                ptr   <= sh_next;
              end
            end
          end
          PH_WR: begin
            sh  <= sh_next;
            cnt <= cnt + 4'd1;
            if (cnt == 4'(BYTE_CLKS - 1)) begin
              cnt       <= '0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {ptr[31:2], 2'b00};
              mem_be    <= 4'b0001 << ptr[1:0];
              mem_wdata <= {4{sh_next[7:0]}};
              ptr       <= ptr + 32'd1;
            end
          end
          default: ;
        endcase
      end else if (fall && phase == PH_RD) begin
        if (!oe) begin
          oe <= 1'b1;
        end else if (ocnt == 4'(WORD_CLKS - 1)) begin
          osh      <= bswap(rd_buf);
          ocnt     <= '0;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_be   <= 4'hF;
          mem_addr <= ptr;
          ptr      <= ptr + 32'd4;
        end else begin
          osh  <= {osh[29:0], 2'b00};
          ocnt <= ocnt + 4'd1;
        end
      end
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_io_oe);

  assert_dn_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_irq));

  assert_irq_follows_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|up_set) |=> !spi_irq_n);

  assert_wr_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1));

  assert_rd_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00 && mem_be == 4'hF));

  assert_oe_only_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe && cs_act) |-> (phase == PH_RD));
endmodule

// File: tb/dspi_target_tb.sv
module dspi_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  io_in = 2'b00;
  logic [1:0]  io_out;
  logic        io_oe, irq_n;
  logic        tgt_ready = 1'b1;
  logic [6:0]  up_set = '0;
  logic [6:0]  dn_irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:63];
  logic [31:0] ref_mem [0:63];
  logic [7:0]  rbuf [0:15];
  logic [7:0]  wbuf [0:15];
  int          n_chk = 0, n_bad = 0;
  int          dn_hits = 0;
  logic [6:0]  dn_last = '0;
  logic [6:0]  exp_pend = '0;
  bit          done = 1'b0;

  dspi_target dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_io_in(io_in), .spi_io_out(io_out), .spi_io_oe(io_oe),
    .spi_irq_n(irq_n), .tgt_ready(tgt_ready), .up_set(up_set),
    .dn_irq(dn_irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] init_word(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [6:0] mask_of(input logic [2:0] idx);
    logic [6:0] m;
    m = '0;
    if (idx != 3'd0) m[idx - 3'd1] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_status(input logic rdy, input logic [6:0] pend);
    logic [31:0] s;
    s = '0;
    s[0] = ~rdy;
    s[8] = rdy;
    for (int k = 0; k < 7; k++) s[9 + k] = pend[k];
    return s;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [7:0] a);
    return ref_mem[a[7:2]][a[1:0]*8 +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (!mem_we) mem_rdata <= mem[mem_addr[7:2]];
      else for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  always @(posedge clk) begin
    if (rst_n && dn_irq != 7'd0) begin
      dn_hits <= dn_hits + 1;
      dn_last <= dn_irq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] d, output logic [1:0] q);
    io_in = d;
    repeat (HALF) @(negedge clk);
    q = io_out;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic [1:0] q;
    for (int k = 0; k < 4; k++) tick(c[7-2*k -: 2], q);
  endtask

  task automatic send_addr(input logic [31:0] a);
    logic [1:0] q;
    for (int k = 0; k < 16; k++) tick(a[31-2*k -: 2], q);
  endtask

  task automatic do_read(input logic [2:0] raise, input logic [2:0] ack,
                         input logic [31:0] a, input int n,
                         output logic [31:0] st, output logic oe_ok);
    logic [1:0] q;
    logic [7:0] b;
    cs_begin();
    send_cmd({1'b1, raise, 1'b0, ack});
    send_addr(a);
    st = '0;
    oe_ok = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick(2'b00, q);
      st = {st[29:0], q};
      if (io_oe !== 1'b1) oe_ok = 1'b0;
    end
    for (int k = 0; k < int'(a[1:0]) * 4; k++) tick(2'b00, q);
    for (int i = 0; i < n; i++) begin
      b = '0;
      for (int k = 0; k < 4; k++) begin
        tick(2'b00, q);
        b = {b[5:0], q};
      end
      rbuf[i] = b;
    end
    cs_end();
    exp_pend &= ~mask_of(ack);
  endtask

  task automatic do_write(input logic [31:0] a, input int n);
    logic [1:0] q;
    cs_begin();
    send_cmd(8'h00);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 4; k++) tick(wbuf[i][7-2*k -: 2], q);
      ref_mem[(a[7:0] + 8'(i)) >> 2][((a[1:0] + 2'(i)) & 2'd3)*8 +: 8] = wbuf[i];
    end
    cs_end();
  endtask

  task automatic pulse_up(input logic [6:0] m);
    @(negedge clk);
    up_set = m;
    @(negedge clk);
    up_set = '0;
    exp_pend |= m;
  endtask

  task automatic read_check(input string tag, input logic [2:0] ack,
                            input logic [31:0] a, input int n);
    logic [31:0] st;
    logic oe_ok;
    logic [31:0] bad_act, bad_exp;
    int nbad;
    do_read(3'd0, ack, a, n, st, oe_ok);
    chk({tag, " R6 status"}, st, exp_status(tgt_ready, exp_pend));
    chk({tag, " R7 oe during turnaround"}, {31'd0, oe_ok}, 32'd1);
    nbad = 0;
    bad_act = '0;
    bad_exp = '0;
    for (int i = 0; i < n; i++)
      if (rbuf[i] !== ref_byte(8'(a[7:0] + 8'(i)))) begin
        if (nbad == 0) begin
          bad_act = {24'd0, rbuf[i]};
          bad_exp = {24'd0, ref_byte(8'(a[7:0] + 8'(i)))};
        end
        nbad++;
      end
    if (n > 0) chk({tag, " R8 read bytes"}, bad_act, bad_exp);
  endtask

  initial begin
    logic [31:0] st;
    logic oe_ok;
    logic [1:0] q;
    int h0;
    int seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < 64; i++) ref_mem[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 reset oe", {31'd0, io_oe}, 32'd0);
    chk("R5 reset irq_n", {31'd0, irq_n}, 32'd1);
    chk("R3 reset dn_irq", {25'd0, dn_irq}, 32'd0);

    read_check("status-only", 3'd0, 32'h0, 0);

    pulse_up(7'b0000001);
    pulse_up(7'b0000100);
    @(negedge clk);
    chk("R5 irq low while pending", {31'd0, irq_n}, 32'd0);
    read_check("pending 1,3", 3'd0, 32'h10, 4);
    read_check("R4 ack 1", 3'd1, 32'h20, 2);
    chk("R5 irq still low", {31'd0, irq_n}, 32'd0);
    read_check("R4 ack 3", 3'd3, 32'h24, 1);
    chk("R5 irq released", {31'd0, irq_n}, 32'd1);
    read_check("after acks", 3'd0, 32'h0, 0);

    pulse_up(7'b1000000);
    read_check("R4 ack 5 not pending", 3'd5, 32'h0, 0);
    read_check("R4 ack 7", 3'd7, 32'h0, 0);
    chk("R5 irq released again", {31'd0, irq_n}, 32'd1);

    h0 = dn_hits;
    cs_begin();
    send_cmd({1'b0, 3'd5, 1'b0, 3'd0});
    cs_end();
    chk("R2 R3 raise count cmd only", 32'(dn_hits - h0), 32'd1);
    chk("R3 raise line", {25'd0, dn_last}, 32'h10);

    h0 = dn_hits;
    do_read(3'd2, 3'd0, 32'h40, 1, st, oe_ok);
    chk("R3 raise count with read", 32'(dn_hits - h0), 32'd1);
    chk("R3 raise line 2", {25'd0, dn_last}, 32'h02);
    h0 = dn_hits;
    read_check("R3 none", 3'd0, 32'h44, 1);
    chk("R3 index 0 no pulse", 32'(dn_hits - h0), 32'd0);

    tgt_ready = 1'b0;
    repeat (2) @(negedge clk);
    read_check("R6 not ready", 3'd0, 32'h0, 0);
    tgt_ready = 1'b1;

    cs_begin();
    send_cmd(8'h80);
    for (int k = 0; k < 7; k++) tick(2'b11, q);
    cs_end();
    chk("R1 abort in address oe", {31'd0, io_oe}, 32'd0);
    read_check("R1 after addr abort", 3'd0, 32'h31, 3);

    cs_begin();
    send_cmd(8'h80);
    send_addr(32'h8);
    for (int k = 0; k < 20; k++) tick(2'b00, q);
    chk("R7 oe in data", {31'd0, io_oe}, 32'd1);
    cs_end();
    chk("R1 abort in data oe", {31'd0, io_oe}, 32'd0);
    read_check("R1 after data abort", 3'd0, 32'h8, 4);

    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(32'h53, 4);
    chk("R9 write word 0x50", mem[20], ref_mem[20]);
    chk("R9 write word 0x54", mem[21], ref_mem[21]);
    read_check("R9 readback", 3'd0, 32'h52, 6);

    for (int it = 0; it < 24; it++) begin
      logic [31:0] a;
      int n;
      a = 32'($urandom_range(0, 240));
      n = $urandom_range(1, 8);
      if ($urandom_range(0, 1) == 1) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(a, n);
        for (int w = int'(a >> 2); w <= int'((a + 32'(n) - 1) >> 2); w++)
          chk("R9 random write", mem[w], ref_mem[w]);
        read_check("R8 R9 random readback", 3'd0, a, n);
      end else begin
        read_check("R8 random read", 3'd0, a, n);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule